// File: doc/BRIEF.md
# Bank Chain Initialization Sequencer

This block is the per-bank part of a serial chain that lets system software give every expansion bank its own number, one bank at a time. The banks are wired in a line. Each bank's token output feeds the token input of the next bank. The first bank carries a head strap. The last bank's token output is returned to every bank as an end-of-chain signal.

A broadcast reset command puts every bank into initialization mode. It also makes the head bank the only active one and asks the bank's chunk-enable register to clear. Each broadcast step command then passes the token one place along the chain. While a bank holds the token, a write to register 2 is steered to its bank-number register, and local status reads are answered by that bank. When a step moves the token off the last bank, every bank drops back to normal mode on the same edge. From then on, register 2 writes go to the protected chunk-select path, and status reads are answered by the bank that the front end reports as selected.

The register front end does the address decoding, the nibble steering and the bank-number compare. It hands this block completed commands, a register-2 write strobe and the compare result. The interrupt logic is not part of this block.

Top module: `bank_chain_seq`

## Requirements
- R1: After synchronous reset, the bank is in normal mode and does not hold the token: `tok_out` is 0, `stat_nib[3]` is 0 and `hs_clr` is 0.
- R2: A command with code 0 puts the bank in initialization mode at the next edge, whatever state it was in. The bank becomes active exactly when `chain_head` is 1.
- R3: `hs_clr` is high for exactly the one cycle that follows the edge that accepts a code 0 command.
- R4: A command with code 1, accepted in initialization mode, loads the active flag at the next edge. The head bank loads 0. Any other bank loads its `tok_in`.
- R5: If `chain_end` is 1 when a code 1 command is accepted in initialization mode, the bank leaves initialization mode and clears its active flag on that edge.
- R6: A code 1 command in normal mode has no effect on `tok_out` or on the mode.
- R7: `tok_out` equals the bank's active flag, so exactly one bank of a chain holds the token during initialization.
- R8: `abn_wr` is `reg2_wr` gated by initialization mode and the active flag. `hs_prot_wr` is `reg2_wr` gated by normal mode. An inactive bank in initialization mode asserts neither.
- R9: `stat_oe` follows `stat_rd`. In initialization mode it is also gated by the active flag. In normal mode it is gated by `sel_match`.
- R10: `stat_nib` reads as follows. Bit 3 is the mode (1 = initialization). Bit 2 is 0 when the bank responds, meaning the active flag in initialization mode or `sel_match` in normal mode. Bit 1 is 1. Bit 0 is 1.
- R11: Command codes other than 0 and 1 (for example 2 and 5) change neither the mode nor the token.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command write is present this cycle |
| cmd_code | input | CMD_W | Command code |
| chain_head | input | 1 | Strap: 1 on the first bank of the chain |
| tok_in | input | 1 | Token from the upstream bank (tie 0 on the head) |
| chain_end | input | 1 | Token output of the last bank in the chain |
| tok_out | output | 1 | Token to the downstream bank |
| reg2_wr | input | 1 | Completed byte write to register 2 |
| abn_wr | output | 1 | Load strobe for the bank-number register |
| hs_prot_wr | output | 1 | Strobe for the protected chunk-select write |
| hs_clr | output | 1 | Clear the chunk-enable register to all off |
| sel_match | input | 1 | Front end reports this bank as selected |
| stat_rd | input | 1 | Local status read this cycle |
| stat_oe | output | 1 | This bank drives the status nibble |
| stat_nib | output | 4 | Local status nibble |

## Verification
The checker assumes a single bank in isolation and takes its inputs as given. It assumes that `tok_in` on a chained bank only reflects an upstream bank's token, and that `chain_end` is high only when the last bank holds the token. The bench meets these assumptions by building a real three-bank chain, with the last bank's output wired back as `chain_end` and shared command inputs. It changes all stimulus on the falling clock edge and holds each command for exactly one cycle.

// File: rtl/bank_chain_pkg.sv
package bank_chain_pkg;

    localparam int CMD_W  = 4;
    localparam int STAT_W = 4;

    localparam logic [CMD_W-1:0] CMD_CHAIN_RESET = CMD_W'(0);
    localparam logic [CMD_W-1:0] CMD_CHAIN_STEP  = CMD_W'(1);

    typedef enum logic [1:0] {
        CK_NONE  = 2'd0,
        CK_RESET = 2'd1,
        CK_STEP  = 2'd2
    } cmd_kind_t;

    typedef struct packed {
        logic init_mode;
        logic active;
    } chain_state_t;

    typedef struct packed {
        logic init_mode;
        logic resp_n;
        logic spare;
        logic irq_n;
    } lstat_t;

    function automatic lstat_t pack_lstat(input logic init_mode, input logic responding);
        lstat_t s;
        s.init_mode = init_mode;
        s.resp_n    = ~responding;
        s.spare     = 1'b1;
        s.irq_n     = 1'b1;
        return s;
    endfunction

endpackage

// File: rtl/chain_cmd_decode.sv
module chain_cmd_decode
    import bank_chain_pkg::*;
#(
    parameter int CW = CMD_W
) (
    input  logic          cmd_valid,
    input  logic [CW-1:0] cmd_code,
    output cmd_kind_t     kind
);
    always_comb begin
        kind = CK_NONE;
        if (cmd_valid) begin
            if (cmd_code == CW'(CMD_CHAIN_RESET))
                kind = CK_RESET;
            else if (cmd_code == CW'(CMD_CHAIN_STEP))
                kind = CK_STEP;
        end
    end
endmodule

// File: rtl/chain_token_stage.sv
module chain_token_stage
    import bank_chain_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  cmd_kind_t    kind,
    input  logic         chain_head,
    input  logic         tok_in,
    input  logic         chain_end,
    output chain_state_t st,
    output logic         clr_pulse
);
    chain_state_t st_q, st_d;
    logic         clr_q;

    always_comb begin
        st_d = st_q;
        unique case (kind)
            CK_RESET: begin
                st_d.init_mode = 1'b1;
                st_d.active    = chain_head;
            end
            CK_STEP: begin
                if (st_q.init_mode) begin
                    if (chain_end) begin
                        st_d.init_mode = 1'b0;
                        st_d.active    = 1'b0;
                    end else begin
                        st_d.active = chain_head ? 1'b0 : tok_in;
                    end
                end
            end
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= '0;
            clr_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            clr_q <= (kind == CK_RESET);
        end
    end

    assign st        = st_q;
    assign clr_pulse = clr_q;
endmodule

// File: rtl/chain_reg2_route.sv
module chain_reg2_route
    import bank_chain_pkg::*;
(
    input  chain_state_t st,
    input  logic         reg2_wr,
    output logic         abn_wr,
    output logic         hs_prot_wr
);
    always_comb begin
        abn_wr     = 1'b0;
        hs_prot_wr = 1'b0;
        if (reg2_wr) begin
            if (st.init_mode)
                abn_wr = st.active;
            else
                hs_prot_wr = 1'b1;
        end
    end
endmodule

// File: rtl/chain_status_fmt.sv
module chain_status_fmt
    import bank_chain_pkg::*;
(
    input  chain_state_t      st,
    input  logic              sel_match,
    input  logic              stat_rd,
    output logic              stat_oe,
    output logic [STAT_W-1:0] stat_nib
);
    logic   responding;
    lstat_t s;

    always_comb begin
        responding = st.init_mode ? st.active : sel_match;
        s          = pack_lstat(st.init_mode, responding);
        stat_oe    = stat_rd & responding;
        stat_nib   = s;
    end
endmodule

// File: rtl/bank_chain_seq.sv
module bank_chain_seq
    import bank_chain_pkg::*;
#(
    parameter int CW = CMD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [CW-1:0]     cmd_code,
    input  logic              chain_head,
    input  logic              tok_in,
    input  logic              chain_end,
    output logic              tok_out,
    input  logic              reg2_wr,
    output logic              abn_wr,
    output logic              hs_prot_wr,
    output logic              hs_clr,
    input  logic              sel_match,
    input  logic              stat_rd,
    output logic              stat_oe,
    output logic [STAT_W-1:0] stat_nib
);
    cmd_kind_t    kind;
    chain_state_t st;

    chain_cmd_decode #(.CW(CW)) u_dec (
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .kind      (kind)
    );

    chain_token_stage u_tok (
        .clk        (clk),
        .rst        (rst),
        .kind       (kind),
        .chain_head (chain_head),
        .tok_in     (tok_in),
        .chain_end  (chain_end),
        .st         (st),
        .clr_pulse  (hs_clr)
    );

    chain_reg2_route u_route (
        .st         (st),
        .reg2_wr    (reg2_wr),
        .abn_wr     (abn_wr),
        .hs_prot_wr (hs_prot_wr)
    );

    chain_status_fmt u_stat (
        .st        (st),
        .sel_match (sel_match),
        .stat_rd   (stat_rd),
        .stat_oe   (stat_oe),
        .stat_nib  (stat_nib)
    );

    assign tok_out = st.active;
endmodule

// File: rtl/bank_chain_seq_chk.sv
module bank_chain_seq_chk #(
    parameter int CW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          cmd_valid,
    input logic [CW-1:0] cmd_code,
    input logic          chain_head,
    input logic          tok_in,
    input logic          chain_end,
    input logic          tok_out,
    input logic          reg2_wr,
    input logic          abn_wr,
    input logic          hs_prot_wr,
    input logic          hs_clr,
    input logic [3:0]    stat_nib
);
    logic rst_cmd, step_cmd;
    assign rst_cmd  = cmd_valid && (cmd_code == CW'(0));
    assign step_cmd = cmd_valid && (cmd_code == CW'(1));

    p_enter_init_r2: assert property (@(posedge clk) disable iff (rst)
        rst_cmd |=> (stat_nib[3] && (tok_out == $past(chain_head))));

    p_clr_follows_r3: assert property (@(posedge clk) disable iff (rst)
        rst_cmd |=> hs_clr);

    p_clr_single_r3: assert property (@(posedge clk) disable iff (rst)
        (hs_clr && !rst_cmd) |=> !hs_clr);

    p_step_capture_r4: assert property (@(posedge clk) disable iff (rst)
        (step_cmd && stat_nib[3] && !chain_end) |=>
            (tok_out == ($past(chain_head) ? 1'b0 : $past(tok_in))));

    p_exhaust_exit_r5: assert property (@(posedge clk) disable iff (rst)
        (step_cmd && stat_nib[3] && chain_end) |=> (!stat_nib[3] && !tok_out));

    p_step_idle_r6: assert property (@(posedge clk) disable iff (rst)
        (step_cmd && !stat_nib[3]) |=> (!stat_nib[3] && $stable(tok_out)));

    p_route_excl_r8: assert property (@(posedge clk) disable iff (rst)
        abn_wr |-> (reg2_wr && stat_nib[3] && tok_out && !hs_prot_wr));

    p_status_fixed_r10: assert property (@(posedge clk) disable iff (rst)
        (stat_nib[1] && stat_nib[0]));
endmodule

bind bank_chain_seq bank_chain_seq_chk #(.CW(CW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .cmd_code   (cmd_code),
    .chain_head (chain_head),
    .tok_in     (tok_in),
    .chain_end  (chain_end),
    .tok_out    (tok_out),
    .reg2_wr    (reg2_wr),
    .abn_wr     (abn_wr),
    .hs_prot_wr (hs_prot_wr),
    .hs_clr     (hs_clr),
    .stat_nib   (stat_nib)
);

// File: tb/bank_chain_seq_test.sv
module bank_chain_seq_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [3:0] cmd_code = 4'd0;
    logic       reg2_wr = 1'b0;
    logic       stat_rd = 1'b0;
    logic [2:0] sel = 3'b000;

    logic [2:0] tok, abn, hsp, clr, oe;
    logic [3:0] nib0, nib1, nib2;
    logic       chain_end;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #4 clk = ~clk;

    assign chain_end = tok[2];

    bank_chain_seq uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .chain_head(1'b1), .tok_in(1'b0), .chain_end(chain_end), .tok_out(tok[0]),
        .reg2_wr(reg2_wr), .abn_wr(abn[0]), .hs_prot_wr(hsp[0]), .hs_clr(clr[0]),
        .sel_match(sel[0]), .stat_rd(stat_rd), .stat_oe(oe[0]), .stat_nib(nib0)
    );
    bank_chain_seq b1 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .chain_head(1'b0), .tok_in(tok[0]), .chain_end(chain_end), .tok_out(tok[1]),
        .reg2_wr(reg2_wr), .abn_wr(abn[1]), .hs_prot_wr(hsp[1]), .hs_clr(clr[1]),
        .sel_match(sel[1]), .stat_rd(stat_rd), .stat_oe(oe[1]), .stat_nib(nib1)
    );
    bank_chain_seq b2 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .chain_head(1'b0), .tok_in(tok[1]), .chain_end(chain_end), .tok_out(tok[2]),
        .reg2_wr(reg2_wr), .abn_wr(abn[2]), .hs_prot_wr(hsp[2]), .hs_clr(clr[2]),
        .sel_match(sel[2]), .stat_rd(stat_rd), .stat_oe(oe[2]), .stat_nib(nib2)
    );

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic send_cmd(input logic [3:0] c);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_code  = c;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    function automatic logic [3:0] modes();
        return {1'b0, nib2[3], nib1[3], nib0[3]};
    endfunction

    task automatic t_reset_state();
        chk("R1 tokens", {1'b0, tok}, 4'b0000);
        chk("R1 modes", modes(), 4'b0000);
        chk("R1 hs_clr", {1'b0, clr}, 4'b0000);
    endtask

    task automatic t_enter_init();
        send_cmd(4'd0);
        chk("R3 hs_clr pulse", {1'b0, clr}, 4'b0111);
        chk("R2 head active", {1'b0, tok}, 4'b0001);
        chk("R2 all init", modes(), 4'b0111);
        @(negedge clk);
        chk("R3 hs_clr single", {1'b0, clr}, 4'b0000);
    endtask

    task automatic t_route_init();
        reg2_wr = 1'b1;
        #1;
        chk("R8 abn only active", {1'b0, abn}, 4'b0001);
        chk("R8 no hs_prot in init", {1'b0, hsp}, 4'b0000);
        reg2_wr = 1'b0;
        #1;
        chk("R8 idle", {1'b0, abn}, 4'b0000);
    endtask

    task automatic t_status_init();
        stat_rd = 1'b1;
        #1;
        chk("R9 oe active only", {1'b0, oe}, 4'b0001);
        chk("R10 active nib", nib0, 4'b1011);
        chk("R10 idle nib", nib1, 4'b1111);
        stat_rd = 1'b0;
        #1;
        chk("R9 oe needs read", {1'b0, oe}, 4'b0000);
    endtask

    task automatic t_ignored_codes();
        send_cmd(4'd2);
        send_cmd(4'd5);
        send_cmd(4'd9);
        chk("R11 tokens kept", {1'b0, tok}, 4'b0001);
        chk("R11 modes kept", modes(), 4'b0111);
    endtask

    task automatic t_steps();
        send_cmd(4'd1);
        chk("R4 step one", {1'b0, tok}, 4'b0010);
        chk("R7 b1 status resp", nib1, 4'b1011);
        send_cmd(4'd1);
        chk("R4 step two", {1'b0, tok}, 4'b0100);
        chk("R4 still init", modes(), 4'b0111);
        reg2_wr = 1'b1;
        #1;
        chk("R8 abn follows token", {1'b0, abn}, 4'b0100);
        reg2_wr = 1'b0;
    endtask

    task automatic t_exhaust();
        send_cmd(4'd1);
        chk("R5 no token", {1'b0, tok}, 4'b0000);
        chk("R5 normal mode", modes(), 4'b0000);
    endtask

    task automatic t_normal();
        send_cmd(4'd1);
        chk("R6 step idle tokens", {1'b0, tok}, 4'b0000);
        chk("R6 step idle modes", modes(), 4'b0000);
        reg2_wr = 1'b1;
        #1;
        chk("R8 hs_prot in normal", {1'b0, hsp}, 4'b0111);
        chk("R8 no abn in normal", {1'b0, abn}, 4'b0000);
        reg2_wr = 1'b0;
        sel = 3'b010;
        stat_rd = 1'b1;
        #1;
        chk("R9 oe by select", {1'b0, oe}, 4'b0010);
        chk("R10 normal resp nib", nib1, 4'b0011);
        chk("R10 normal idle nib", nib0, 4'b0111);
        stat_rd = 1'b0;
        sel = 3'b000;
    endtask

    task automatic t_restart();
        send_cmd(4'd0);
        send_cmd(4'd1);
        chk("R4 restart step", {1'b0, tok}, 4'b0010);
        send_cmd(4'd0);
        chk("R2 reset mid chain", {1'b0, tok}, 4'b0001);
        chk("R3 pulse again", {1'b0, clr}, 4'b0111);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_enter_init();
        t_route_init();
        t_status_init();
        t_ignored_codes();
        t_steps();
        t_exhaust();
        t_normal();
        t_restart();
        @(negedge clk);
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule